// File: doc/BRIEF.md
# Bit-Clock Loss Supervisor

This block watches a serial-bus bit clock that arrives unrelated to the local system clock and tells the system when that clock stops and when it comes back. The raw bit clock passes through a short synchronizer chain. Its rising edges are then found in the system-clock domain. Each rising edge reloads a programmable down-counter. If the counter runs down to zero before another edge arrives, the block sends out a one-cycle loss interrupt and raises a clock-off status flag. The next rising edge clears the flag and sends out a separate one-cycle activation interrupt.

There is no data stream here. Every pin is a plain control or status level or a pulse, with no valid/ready handshake and no back-pressure. Software or a surrounding controller picks the reload value from the ratio of the two clock rates. With a running bit clock, the interval between rising edges, measured in system cycles, must not be longer than the reload value. The enable input parks the supervisor: the counter is held at the reload value and all indications are kept quiet.

Top module: `clkloss_sup`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `loss_irq`, `act_irq` and `clk_off` are 0.
- R2: The raw bit clock is synchronized through two flops. If a rising edge is first sampled at system edge k and `clk_off` is 1, `act_irq` is 1 for the cycle after edge k+2.
- R3: Every detected rising edge loads the counter with `reload_val`. Changing `reload_val` between edges does not affect the countdown already in progress.
- R4: With reload value N ≥ 1 and no further edges, `loss_irq` pulses in the cycle after edge k+2+N, where k is the system edge that first sampled the last bit-clock rise. A bit clock whose rising edges are P system cycles apart never causes a loss when N ≥ P, and causes one loss per period when N < P.
- R5: `loss_irq` is a one-cycle pulse. After it, the counter stays at zero and no further loss is reported until a new rising edge reloads it.
- R6: `clk_off` goes to 1 in the same cycle as the loss pulse. It returns to 0 in the same cycle as the activation pulse.
- R7: `act_irq` is a one-cycle pulse, given only for the first rising edge after a loss. Rising edges seen while `clk_off` is 0 produce no activation.
- R8: A reload value of 0 turns the timeout off: a loaded zero never produces a loss.
- R9: While `sup_en` is 0, the counter is held at `reload_val`, `clk_off` is cleared, and no interrupt is produced. After `sup_en` rises with no bit-clock edges, `loss_irq` pulses in the cycle after the (N-1)-th edge that follows the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_raw | input | 1 | Unsynchronized bit clock being supervised |
| sup_en | input | 1 | Supervisor enable |
| reload_val | input | CNT_W | Timeout in system cycles, loaded on each bit-clock rise |
| loss_irq | output | 1 | One-cycle pulse when the bit clock is judged stopped |
| act_irq | output | 1 | One-cycle pulse on the first bit-clock rise after a loss |
| clk_off | output | 1 | Status: bit clock currently judged stopped |

## Verification
The main test sweeps the bit-clock period P from 2 to 8 system cycles against reload values from 0 to 10. It counts loss and activation pulses over a burst of periods, which checks the N ≥ P boundary exactly and confirms that zero disables the timeout. Single isolated edges measure the exact activation latency and loss latency for several reload values, which would expose an extra or missing synchronizer stage or an off-by-one in the counter. Separate patterns cover a reload change in the middle of a countdown, edges arriving while `clk_off` is low, and an enable release with no clock. These show that the reload value is sampled only at edges, that spurious activations are absent, and that the enabled countdown starts at the right point.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;
  // events handed from the timer to the indication stage
  typedef struct packed {
    logic rise;
    logic expire;
  } sup_evt_t;
endpackage

// File: rtl/clkloss_edge.sv
module clkloss_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= 1'b0;
    else        pipe_q[0] <= raw_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= 1'b0;
      else        pipe_q[g] <= pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pipe_q[STAGES-1];
  end

  assign rise_o = pipe_q[STAGES-1] & ~prev_q;

  AST_RISE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/clkloss_timer.sv
module clkloss_timer
  import clkloss_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] reload_i,
  output sup_evt_t         evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!en_i || rise_i)  cnt_q <= reload_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - ONE;
  end

  assign evt_o.rise   = en_i & rise_i;
  assign evt_o.expire = en_i & ~rise_i & (cnt_q == ONE);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !rise_i && cnt_q == '0) |=> (cnt_q == '0)); // R5
  AST_RELOAD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && rise_i) |=> (cnt_q == $past(reload_i))); // R3
endmodule

// File: rtl/clkloss_flags.sv
module clkloss_flags
  import clkloss_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  sup_evt_t evt_i,
  output logic     loss_o,
  output logic     act_o,
  output logic     off_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loss_o <= 1'b0;
      act_o  <= 1'b0;
      off_o  <= 1'b0;
    end else if (!en_i) begin
      loss_o <= 1'b0;
      act_o  <= 1'b0;
      off_o  <= 1'b0;
    end else begin
      loss_o <= evt_i.expire;
      act_o  <= evt_i.rise & off_o;
      if (evt_i.expire)    off_o <= 1'b1;
      else if (evt_i.rise) off_o <= 1'b0;
    end
  end

  AST_ACT_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_o) |-> $past(off_o)); // R7
  AST_OFF_WITH_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_o) |-> loss_o); // R6
endmodule

// File: rtl/clkloss_sup.sv
module clkloss_sup
  import clkloss_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_raw,
  input  logic             sup_en,
  input  logic [CNT_W-1:0] reload_val,
  output logic             loss_irq,
  output logic             act_irq,
  output logic             clk_off
);
  logic     rise;
  sup_evt_t evt;

  clkloss_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .raw_i(bclk_raw), .rise_o(rise)
  );

  clkloss_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(sup_en), .rise_i(rise),
    .reload_i(reload_val), .evt_o(evt)
  );

  clkloss_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en_i(sup_en), .evt_i(evt),
    .loss_o(loss_irq), .act_o(act_irq), .off_o(clk_off)
  );

  AST_LOSS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    loss_irq |=> !loss_irq); // R5
  AST_ACT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    act_irq |=> !act_irq); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_en |=> (!loss_irq && !act_irq && !clk_off)); // R9
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(loss_irq && act_irq)); // R6
endmodule

// File: tb/clkloss_sup_tb.sv
module clkloss_sup_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk_raw = 1'b0;
  logic       sup_en = 1'b0;
  logic [7:0] reload_val = 8'd0;
  logic       loss_irq, act_irq, clk_off;

  int n_checks = 0;
  int n_fail = 0;
  int loss_cnt = 0;
  int act_cnt = 0;

  always #10 clk = ~clk;

  clkloss_sup #(.CNT_W(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_raw(bclk_raw), .sup_en(sup_en),
    .reload_val(reload_val), .loss_irq(loss_irq), .act_irq(act_irq),
    .clk_off(clk_off)
  );

  always @(negedge clk) begin
    if (loss_irq) loss_cnt++;
    if (act_irq)  act_cnt++;
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // force a loss so clk_off is 1 and counter sits at zero
  task automatic warmup();
    reload_val = 8'd3;
    bclk_raw = 1'b1; tick(1);
    bclk_raw = 1'b0; tick(12);
    check(clk_off == 1'b1, "R6 clk_off after loss", int'(clk_off), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    tick(3);
    check(!loss_irq && !act_irq && !clk_off, "R1 in reset", int'({loss_irq, act_irq, clk_off}), 0);
    rst_n = 1'b1; tick(1);
    check(!loss_irq && !act_irq && !clk_off, "R1 after reset", int'({loss_irq, act_irq, clk_off}), 0);
    sup_en = 1'b1; tick(2);

    // exact latencies from a single isolated edge
    for (int n = 1; n <= 6; n++) begin
      int c_act, c_loss, off_at_act, off_at_loss;
      warmup();
      reload_val = 8'(n);
      c_act = -1; c_loss = -1; off_at_act = -1; off_at_loss = -1;
      bclk_raw = 1'b1; tick(1); bclk_raw = 1'b0;
      for (int c = 1; c <= n + 10; c++) begin
        if (act_irq && c_act < 0)   begin c_act = c;  off_at_act = int'(clk_off); end
        if (loss_irq && c_loss < 0) begin c_loss = c; off_at_loss = int'(clk_off); end
        tick(1);
      end
      check(c_act == 3, "R2 activation latency", c_act, 3);
      check(off_at_act == 0, "R6 clear with activation", off_at_act, 0);
      check(c_loss == n + 3, "R4 loss latency", c_loss, n + 3);
      check(off_at_loss == 1, "R6 set with loss", off_at_loss, 1);
    end

    // reload changed during countdown is not used
    begin
      int c_loss;
      warmup();
      reload_val = 8'd10; c_loss = -1;
      bclk_raw = 1'b1; tick(1); bclk_raw = 1'b0;
      for (int c = 1; c <= 25; c++) begin
        if (c == 4) reload_val = 8'd1;
        if (loss_irq && c_loss < 0) c_loss = c;
        tick(1);
      end
      check(c_loss == 13, "R3 reload sampled at edge only", c_loss, 13);
    end

    // period/reload sweep, counting pulses
    for (int p = 2; p <= 8; p++) begin
      for (int n = 0; n <= 10; n++) begin
        int h, exp_l, exp_a;
        h = p / 2;
        warmup();
        reload_val = 8'(n);
        loss_cnt = 0; act_cnt = 0;
        for (int k = 0; k < 5; k++) begin
          bclk_raw = 1'b1; tick(h);
          bclk_raw = 1'b0; tick(p - h);
        end
        tick(n + 20);
        exp_l = (n == 0) ? 0 : ((n < p) ? 5 : 1);
        exp_a = (n == 0) ? 1 : ((n < p) ? 5 : 1);
        check(loss_cnt == exp_l, (n == 0) ? "R8 zero reload losses" : "R4 sweep losses", loss_cnt, exp_l);
        check(act_cnt == exp_a, "R7 sweep activations", act_cnt, exp_a);
        if (n > 0) check(clk_off == 1'b1, "R5 stays off after loss", int'(clk_off), 1);
      end
    end

    // long idle after loss: no repeated loss
    warmup();
    loss_cnt = 0; tick(40);
    check(loss_cnt == 0, "R5 no repeat loss", loss_cnt, 0);

    // edges while clk_off is 0 produce no activation
    reload_val = 8'd20;
    bclk_raw = 1'b1; tick(1); bclk_raw = 1'b0; tick(5);
    act_cnt = 0;
    for (int k = 0; k < 4; k++) begin
      bclk_raw = 1'b1; tick(2); bclk_raw = 1'b0; tick(3);
    end
    check(act_cnt == 0, "R7 no activation while on", act_cnt, 0);

    // disable behaviour
    warmup();
    sup_en = 1'b0; reload_val = 8'd2; tick(1);
    check(clk_off == 1'b0, "R9 disable clears status", int'(clk_off), 0);
    loss_cnt = 0; act_cnt = 0;
    for (int k = 0; k < 6; k++) begin
      bclk_raw = 1'b1; tick(1); bclk_raw = 1'b0; tick(5);
    end
    tick(10);
    check(loss_cnt + act_cnt == 0, "R9 quiet while disabled", loss_cnt + act_cnt, 0);
    for (int n = 1; n <= 5; n++) begin
      int c_loss;
      sup_en = 1'b0; reload_val = 8'(n); tick(3);
      c_loss = -1;
      sup_en = 1'b1; tick(1);
      for (int c = 1; c <= n + 8; c++) begin
        if (loss_irq && c_loss < 0) c_loss = c;
        tick(1);
      end
      check(c_loss == n, "R9 loss after enable", c_loss, n);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule